// File: doc/BRIEF.md
# Serial Transfer Buffer and Event Controller

This block sits between a register-style host port and a serial shift engine. It holds two word FIFOs: a transmit queue that the host fills and the engine drains, and a receive queue that the engine fills and the host drains. Both FIFOs are parameterised in depth and word width. The defaults are 32 entries of 16 bits, and 64 entries is the usual alternative depth. The block also reports the fill level of each queue, a status word and a five-bit event vector. Each event can be masked, and together they drive a single interrupt line.

Two kinds of event exist. Two events track the FIFO levels against programmable thresholds and follow the levels from cycle to cycle. Three events are sticky error flags that stay set until a write to the clear register removes them. While the enable input is low, both queues are held empty.

The host port has a 4-bit address, a write strobe and a read strobe. Read data is combinational from the address. The address map is: 0 data (a write pushes to the transmit FIFO, a read pops the receive FIFO), 1 transmit level, 2 receive level, 3 transmit threshold, 4 receive threshold, 5 event mask, 6 status, 7 raw events, 8 masked events, 9 event clear (write only). Unmapped addresses read zero.

Top module: `sbe_top`

## Requirements
- R1: A write to address 0 while enabled appends the word to the transmit FIFO. The engine pops words in the order written. Address 1 reads the current entry count, and `eng_tx_valid` is high while the count is non-zero.
- R2: An engine push while enabled appends to the receive FIFO. A read of address 0 returns the oldest word and removes it. Address 2 reads the current entry count.
- R3: A write to address 0 while the transmit FIFO is full is dropped: the level and contents are unchanged, and raw event bit 1 (transmit overflow) becomes set.
- R4: A read of address 0 while the receive FIFO is empty returns zero and sets raw event bit 2 (receive underflow).
- R5: An engine push while the receive FIFO is full is dropped and sets raw event bit 3 (receive overflow).
- R6: Raw event bit 0 is high while the transmit level is at or below the transmit threshold. Raw event bit 4 is high while the receive level is at least the receive threshold plus one.
- R7: Bits 1, 2 and 3 of the raw vector stay set until cleared through address 9. Clear bit 0 clears all three. Clear bit 1 clears receive underflow, clear bit 2 clears receive overflow and clear bit 3 clears transmit overflow. A new event in the same cycle as its clear leaves the bit set.
- R8: Address 8 reads the raw vector ANDed with the mask at address 5. `irq` is the OR of the masked bits.
- R9: While `enable` is low, both FIFOs are emptied and their levels read zero from the next cycle on. Data writes are ignored and raise no event.
- R10: The threshold registers at addresses 3 and 4 take writes only while `enable` is low. A write made while enabled leaves the stored value unchanged.
- R11: Status at address 6 is: bit 0 engine busy, bit 1 transmit full, bit 2 transmit empty, bit 3 receive empty, bit 4 receive full, bit 5 target-side transmit busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Block enable; low flushes both FIFOs |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe (pops on data address) |
| reg_addr | input | 4 | Host register address |
| reg_wdata | input | DW | Host write data |
| reg_rdata | output | DW | Host read data, combinational from address |
| eng_tx_pop | input | 1 | Engine takes the head transmit word |
| eng_tx_data | output | DW | Head of transmit FIFO, zero when empty |
| eng_tx_valid | output | 1 | Transmit FIFO holds at least one word |
| eng_rx_push | input | 1 | Engine delivers a received word |
| eng_rx_data | input | DW | Received word |
| eng_busy | input | 1 | Engine busy indication, reported in status |
| eng_tgt_busy | input | 1 | Target-side transmit busy, reported in status |
| irq | output | 1 | OR of masked events |

## Verification
The bench fills the transmit queue to its last entry and writes once more. A design that compared against the wrong full count would either lose a real word or overwrite the oldest one, and the drained sequence would show it. It pushes a received word in the same cycle as a clear of receive overflow, so a design that gave the clear priority would miss the event. It checks the receive threshold at exactly the threshold and one above it, because an off-by-one there fires the interrupt one word early. Threshold writes are tried while enabled to catch a lock that is missing, and data writes are tried while disabled to catch a flush that only acts on the falling edge of enable.

// File: rtl/sbe_pkg.sv
// Shared constants for the serial transfer buffer: register addresses,
// event and clear bit positions, status bit positions.
package sbe_pkg;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_DATA  = 4'd0;
    localparam logic [ADDR_W-1:0] A_TXLVL = 4'd1;
    localparam logic [ADDR_W-1:0] A_RXLVL = 4'd2;
    localparam logic [ADDR_W-1:0] A_TXTHR = 4'd3;
    localparam logic [ADDR_W-1:0] A_RXTHR = 4'd4;
    localparam logic [ADDR_W-1:0] A_MASK  = 4'd5;
    localparam logic [ADDR_W-1:0] A_STAT  = 4'd6;
    localparam logic [ADDR_W-1:0] A_RAW   = 4'd7;
    localparam logic [ADDR_W-1:0] A_MSKD  = 4'd8;
    localparam logic [ADDR_W-1:0] A_CLR   = 4'd9;

    localparam int EVT_W    = 5;
    localparam int EV_TXLOW = 0;
    localparam int EV_TXOVF = 1;
    localparam int EV_RXUNF = 2;
    localparam int EV_RXOVF = 3;
    localparam int EV_RXHI  = 4;

    localparam int CLR_W    = 4;
    localparam int CL_ALL   = 0;
    localparam int CL_RXUNF = 1;
    localparam int CL_RXOVF = 2;
    localparam int CL_TXOVF = 3;

    localparam int STAT_W   = 6;
    localparam int ST_BUSY  = 0;
    localparam int ST_TXF   = 1;
    localparam int ST_TXE   = 2;
    localparam int ST_RXE   = 3;
    localparam int ST_RXF   = 4;
    localparam int ST_TGTB  = 5;
endpackage

// File: rtl/sbe_fifo.sv
// Synchronous word FIFO with an explicit entry counter.
// Assumes: callers gate push with !full and pop with !empty themselves, or
// accept that such requests are silently ignored here; flush dominates.
// The head word is presented combinationally and reads zero when empty.
module sbe_fifo #(
    parameter int DEPTH = 32,
    parameter int DW    = 16,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] rdata,
    output logic [LW-1:0] level,
    output logic          full,
    output logic          empty
);
    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [LW-1:0] count;
    logic          do_push, do_pop;

    assign full    = (count == LW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign level   = count;
    assign rdata   = empty ? '0 : mem[rd_ptr];

    // Advance a pointer, wrapping at the last entry.
    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Store an accepted word at the write pointer.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    // Maintain pointers and count; reset and flush empty the queue.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/sbe_cfg.sv
// Configuration registers: two FIFO thresholds and the event mask.
// Assumes: thresholds are only meaningful while the block is disabled, so
// writes to them are refused while enable is high; the mask is always writable.
module sbe_cfg #(
    parameter int TW = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       enable,
    input  logic                       wr,
    input  logic [sbe_pkg::ADDR_W-1:0] addr,
    input  logic [TW-1:0]              thr_wdata,
    input  logic [sbe_pkg::EVT_W-1:0]  mask_wdata,
    output logic [TW-1:0]              tx_thr,
    output logic [TW-1:0]              rx_thr,
    output logic [sbe_pkg::EVT_W-1:0]  mask
);
    import sbe_pkg::*;

    // Capture thresholds, locked while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_thr <= '0;
            rx_thr <= '0;
        end else if (wr && !enable) begin
            if (addr == A_TXTHR) tx_thr <= thr_wdata;
            if (addr == A_RXTHR) rx_thr <= thr_wdata;
        end
    end

    // Capture the event mask at any time.
    always_ff @(posedge clk) begin
        if (!rst_n)                     mask <= '0;
        else if (wr && addr == A_MASK)  mask <= mask_wdata;
    end
endmodule

// File: rtl/sbe_evt.sv
// Event vector: two level comparisons against thresholds and three sticky
// error flags, masked and reduced to one interrupt line.
// Assumes: set strobes are single-cycle pulses; a set wins over a clear
// arriving in the same cycle.
module sbe_evt #(
    parameter int LW = 6,
    parameter int TW = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [LW-1:0]             tx_level,
    input  logic [LW-1:0]             rx_level,
    input  logic [TW-1:0]             tx_thr,
    input  logic [TW-1:0]             rx_thr,
    input  logic                      set_txovf,
    input  logic                      set_rxunf,
    input  logic                      set_rxovf,
    input  logic                      clr_wr,
    input  logic [sbe_pkg::CLR_W-1:0] clr_bits,
    input  logic [sbe_pkg::EVT_W-1:0] mask,
    output logic [sbe_pkg::EVT_W-1:0] raw,
    output logic [sbe_pkg::EVT_W-1:0] masked,
    output logic                      irq
);
    import sbe_pkg::*;

    logic txovf_q, rxunf_q, rxovf_q;
    logic kill_txovf, kill_rxunf, kill_rxovf;

    assign kill_txovf = clr_wr && (clr_bits[CL_ALL] || clr_bits[CL_TXOVF]);
    assign kill_rxunf = clr_wr && (clr_bits[CL_ALL] || clr_bits[CL_RXUNF]);
    assign kill_rxovf = clr_wr && (clr_bits[CL_ALL] || clr_bits[CL_RXOVF]);

    // Sticky error flags: set on event, cleared by the clear register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txovf_q <= 1'b0;
            rxunf_q <= 1'b0;
            rxovf_q <= 1'b0;
        end else begin
            txovf_q <= set_txovf || (txovf_q && !kill_txovf);
            rxunf_q <= set_rxunf || (rxunf_q && !kill_rxunf);
            rxovf_q <= set_rxovf || (rxovf_q && !kill_rxovf);
        end
    end

    // Assemble raw vector, apply mask, reduce to interrupt.
    always_comb begin
        raw           = '0;
        raw[EV_TXLOW] = (tx_level <= LW'(tx_thr));
        raw[EV_TXOVF] = txovf_q;
        raw[EV_RXUNF] = rxunf_q;
        raw[EV_RXOVF] = rxovf_q;
        raw[EV_RXHI]  = (rx_level > LW'(rx_thr));
        masked        = raw & mask;
        irq           = |masked;
    end
endmodule

// File: rtl/sbe_top.sv
// Serial transfer buffer top: host register port, transmit and receive
// FIFOs, configuration and event logic.
// Assumes: one host access per cycle; read data is combinational and a read
// of the data address pops at the clock edge ending the access.
module sbe_top #(
    parameter int DEPTH = 32,
    parameter int DW    = 16,
    localparam int LW   = $clog2(DEPTH + 1),
    localparam int TW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       enable,
    input  logic                       reg_wr,
    input  logic                       reg_rd,
    input  logic [sbe_pkg::ADDR_W-1:0] reg_addr,
    input  logic [DW-1:0]              reg_wdata,
    output logic [DW-1:0]              reg_rdata,
    input  logic                       eng_tx_pop,
    output logic [DW-1:0]              eng_tx_data,
    output logic                       eng_tx_valid,
    input  logic                       eng_rx_push,
    input  logic [DW-1:0]              eng_rx_data,
    input  logic                       eng_busy,
    input  logic                       eng_tgt_busy,
    output logic                       irq
);
    import sbe_pkg::*;

    logic [LW-1:0]     tx_level, rx_level;
    logic              tx_full, tx_empty, rx_full, rx_empty;
    logic [DW-1:0]     rx_head;
    logic [TW-1:0]     tx_thr, rx_thr;
    logic [EVT_W-1:0]  mask_q, raw_vec, masked_vec;
    logic [STAT_W-1:0] status;
    logic              host_push, host_pop, eng_push, eng_pop, flush;
    logic              clr_wr;

    assign flush     = !enable;
    assign host_push = enable && reg_wr && (reg_addr == A_DATA);
    assign host_pop  = enable && reg_rd && (reg_addr == A_DATA);
    assign eng_push  = enable && eng_rx_push;
    assign eng_pop   = enable && eng_tx_pop;
    assign clr_wr    = reg_wr && (reg_addr == A_CLR);

    sbe_fifo #(.DEPTH(DEPTH), .DW(DW)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push(host_push), .wdata(reg_wdata),
        .pop(eng_pop), .rdata(eng_tx_data),
        .level(tx_level), .full(tx_full), .empty(tx_empty)
    );

    sbe_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push(eng_push), .wdata(eng_rx_data),
        .pop(host_pop), .rdata(rx_head),
        .level(rx_level), .full(rx_full), .empty(rx_empty)
    );

    sbe_cfg #(.TW(TW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .wr(reg_wr), .addr(reg_addr),
        .thr_wdata(reg_wdata[TW-1:0]), .mask_wdata(reg_wdata[EVT_W-1:0]),
        .tx_thr(tx_thr), .rx_thr(rx_thr), .mask(mask_q)
    );

    sbe_evt #(.LW(LW), .TW(TW)) u_evt (
        .clk(clk), .rst_n(rst_n),
        .tx_level(tx_level), .rx_level(rx_level),
        .tx_thr(tx_thr), .rx_thr(rx_thr),
        .set_txovf(host_push && tx_full),
        .set_rxunf(host_pop && rx_empty),
        .set_rxovf(eng_push && rx_full),
        .clr_wr(clr_wr), .clr_bits(reg_wdata[CLR_W-1:0]),
        .mask(mask_q), .raw(raw_vec), .masked(masked_vec), .irq(irq)
    );

    assign eng_tx_valid = !tx_empty;

    // Gather the status word from FIFO flags and engine indications.
    always_comb begin
        status          = '0;
        status[ST_BUSY] = eng_busy;
        status[ST_TXF]  = tx_full;
        status[ST_TXE]  = tx_empty;
        status[ST_RXE]  = rx_empty;
        status[ST_RXF]  = rx_full;
        status[ST_TGTB] = eng_tgt_busy;
    end

    // Select host read data by address.
    always_comb begin
        case (reg_addr)
            A_DATA:  reg_rdata = rx_head;
            A_TXLVL: reg_rdata = DW'(tx_level);
            A_RXLVL: reg_rdata = DW'(rx_level);
            A_TXTHR: reg_rdata = DW'(tx_thr);
            A_RXTHR: reg_rdata = DW'(rx_thr);
            A_MASK:  reg_rdata = DW'(mask_q);
            A_STAT:  reg_rdata = DW'(status);
            A_RAW:   reg_rdata = DW'(raw_vec);
            A_MSKD:  reg_rdata = DW'(masked_vec);
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/sbe_chk.sv
// Property checker for sbe_top, attached by bind. Observes levels,
// thresholds, event vector and host strobes.
module sbe_chk #(
    parameter int DEPTH = 32,
    parameter int LW    = 6,
    parameter int TW    = 5
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       enable,
    input logic                       reg_wr,
    input logic [sbe_pkg::ADDR_W-1:0] reg_addr,
    input logic [LW-1:0]              tx_level,
    input logic [LW-1:0]              rx_level,
    input logic [TW-1:0]              tx_thr,
    input logic [TW-1:0]              rx_thr,
    input logic [sbe_pkg::EVT_W-1:0]  raw_vec,
    input logic [sbe_pkg::EVT_W-1:0]  mask_q,
    input logic                       irq
);
    import sbe_pkg::*;

    p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (tx_level == '0 && rx_level == '0));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(tx_level) <= DEPTH && int'(rx_level) <= DEPTH));

    p_irq_or_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq == ((raw_vec & mask_q) != '0));

    p_txovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_vec[EV_TXOVF] && !(reg_wr && reg_addr == A_CLR)) |=> raw_vec[EV_TXOVF]);

    p_rxovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_vec[EV_RXOVF] && !(reg_wr && reg_addr == A_CLR)) |=> raw_vec[EV_RXOVF]);

    p_rxhi_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
        raw_vec[EV_RXHI] == (int'(rx_level) >= int'(rx_thr) + 1));

    p_thr_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        enable |=> ($stable(tx_thr) && $stable(rx_thr)));

    p_tx_level_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        enable |=> (!enable || (int'(tx_level) <= int'($past(tx_level)) + 1 &&
                                int'($past(tx_level)) <= int'(tx_level) + 1)));
endmodule

bind sbe_top sbe_chk #(.DEPTH(DEPTH), .LW(LW), .TW(TW)) u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .reg_wr(reg_wr), .reg_addr(reg_addr),
    .tx_level(tx_level), .rx_level(rx_level),
    .tx_thr(tx_thr), .rx_thr(rx_thr),
    .raw_vec(raw_vec), .mask_q(mask_q), .irq(irq)
);

// File: tb/sim_sbe_top.sv
// Directed bench for sbe_top: one task per scenario, each checking itself.
module sim_sbe_top;
    localparam int DEPTH = 32;
    localparam int DW    = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic          reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0]    reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          eng_tx_pop = 1'b0;
    logic [DW-1:0] eng_tx_data;
    logic          eng_tx_valid;
    logic          eng_rx_push = 1'b0;
    logic [DW-1:0] eng_rx_data = '0;
    logic          eng_busy = 1'b0, eng_tgt_busy = 1'b0;
    logic          irq;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    sbe_top #(.DEPTH(DEPTH), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data), .eng_tx_valid(eng_tx_valid),
        .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
        .eng_busy(eng_busy), .eng_tgt_busy(eng_tgt_busy), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output int v);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 v = int'(reg_rdata);
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    task automatic eng_push(input logic [DW-1:0] d);
        @(negedge clk);
        eng_rx_push = 1'b1; eng_rx_data = d;
        @(posedge clk); #1;
        eng_rx_push = 1'b0;
    endtask

    task automatic eng_pop(output int v);
        @(negedge clk);
        eng_tx_pop = 1'b1;
        #1 v = int'(eng_tx_data);
        @(posedge clk); #1;
        eng_tx_pop = 1'b0;
    endtask

    task automatic t_reset();
        int v;
        rd(4'd1, v); chk("R1 reset tx level", v, 0);
        rd(4'd2, v); chk("R2 reset rx level", v, 0);
        rd(4'd6, v); chk("R11 reset status", v, 32'h0C);
        rd(4'd7, v); chk("R6 reset raw", v, 32'h01);
        chk("R8 reset irq", int'(irq), 0);
    endtask

    task automatic t_thresholds();
        int v;
        wr(4'd3, 16'd4);
        wr(4'd4, 16'd2);
        rd(4'd3, v); chk("R10 tx thr disabled write", v, 4);
        rd(4'd4, v); chk("R10 rx thr disabled write", v, 2);
        @(negedge clk) enable = 1'b1;
        wr(4'd3, 16'd9);
        wr(4'd4, 16'd7);
        rd(4'd3, v); chk("R10 tx thr locked", v, 4);
        rd(4'd4, v); chk("R10 rx thr locked", v, 2);
    endtask

    task automatic t_tx_path();
        int v;
        for (int i = 0; i < 3; i++) wr(4'd0, 16'hA000 + 16'(i));
        rd(4'd1, v); chk("R1 tx level 3", v, 3);
        rd(4'd7, v); chk("R6 tx low at 3<=4", v & 1, 1);
        chk("R1 tx valid", int'(eng_tx_valid), 1);
        for (int i = 3; i < 5; i++) wr(4'd0, 16'hA000 + 16'(i));
        rd(4'd7, v); chk("R6 tx low clear at 5", v & 1, 0);
        for (int i = 0; i < 5; i++) begin
            eng_pop(v); chk("R1 tx order", v, 32'hA000 + i);
        end
        rd(4'd1, v); chk("R1 tx drained", v, 0);
        chk("R1 tx valid low", int'(eng_tx_valid), 0);
    endtask

    task automatic t_rx_path();
        int v;
        eng_push(16'hB000); eng_push(16'hB001);
        rd(4'd2, v); chk("R2 rx level 2", v, 2);
        rd(4'd7, v); chk("R6 rx hi at level=thr", (v >> 4) & 1, 0);
        eng_push(16'hB002);
        rd(4'd7, v); chk("R6 rx hi at thr+1", (v >> 4) & 1, 1);
        rd(4'd6, v); chk("R11 rx not empty", (v >> 3) & 1, 0);
        for (int i = 0; i < 3; i++) begin
            rd(4'd0, v); chk("R2 rx order", v, 32'hB000 + i);
        end
        rd(4'd2, v); chk("R2 rx drained", v, 0);
    endtask

    task automatic t_underflow();
        int v;
        rd(4'd0, v); chk("R4 empty read zero", v, 0);
        rd(4'd7, v); chk("R4 underflow set", (v >> 2) & 1, 1);
        rd(4'd2, v); chk("R4 level still zero", v, 0);
        wr(4'd9, 16'h2);
        rd(4'd7, v); chk("R7 underflow cleared", (v >> 2) & 1, 0);
    endtask

    task automatic t_mask();
        int v;
        for (int i = 0; i < 3; i++) eng_push(16'hD000 + 16'(i));
        wr(4'd5, 16'h10);
        #1 chk("R8 irq from rx hi", int'(irq), 1);
        rd(4'd8, v); chk("R8 masked vector", v, 32'h10);
        wr(4'd5, 16'h08);
        #1 chk("R8 irq masked off", int'(irq), 0);
        rd(4'd8, v); chk("R8 masked vector empty", v, 0);
        wr(4'd5, 16'h00);
        for (int i = 0; i < 3; i++) rd(4'd0, v);
    endtask

    task automatic t_tx_overflow();
        int v;
        for (int i = 0; i < DEPTH; i++) wr(4'd0, 16'h1000 + 16'(i));
        rd(4'd7, v); chk("R3 no overflow at exactly full", (v >> 1) & 1, 0);
        rd(4'd6, v); chk("R11 tx full", (v >> 1) & 1, 1);
        wr(4'd0, 16'hDEAD);
        rd(4'd1, v); chk("R3 tx level capped", v, DEPTH);
        rd(4'd7, v); chk("R3 tx overflow set", (v >> 1) & 1, 1);
        for (int i = 0; i < DEPTH; i++) begin
            eng_pop(v); chk("R3 tx content kept", v, 32'h1000 + i);
        end
        rd(4'd6, v); chk("R11 tx empty", (v >> 2) & 1, 1);
        rd(4'd7, v); chk("R7 tx overflow sticky", (v >> 1) & 1, 1);
        wr(4'd9, 16'h1);
        rd(4'd7, v); chk("R7 clear all", v & 32'h0E, 0);
    endtask

    task automatic t_rx_overflow();
        int v;
        for (int i = 0; i < DEPTH; i++) eng_push(16'hC000 + 16'(i));
        rd(4'd6, v); chk("R11 rx full", (v >> 4) & 1, 1);
        rd(4'd7, v); chk("R5 no overflow at exactly full", (v >> 3) & 1, 0);
        eng_push(16'hBEEF);
        rd(4'd2, v); chk("R5 rx level capped", v, DEPTH);
        rd(4'd7, v); chk("R5 rx overflow set", (v >> 3) & 1, 1);
        wr(4'd9, 16'h8);
        rd(4'd7, v); chk("R7 tx clear leaves rx overflow", (v >> 3) & 1, 1);
        wr(4'd9, 16'h4);
        rd(4'd7, v); chk("R7 rx overflow cleared", (v >> 3) & 1, 0);
        @(negedge clk);
        eng_rx_push = 1'b1; eng_rx_data = 16'hFACE;
        reg_wr = 1'b1; reg_addr = 4'd9; reg_wdata = 16'h4;
        @(posedge clk); #1;
        eng_rx_push = 1'b0; reg_wr = 1'b0;
        rd(4'd7, v); chk("R7 set wins over clear", (v >> 3) & 1, 1);
        for (int i = 0; i < DEPTH; i++) begin
            rd(4'd0, v); chk("R5 rx content kept", v, 32'hC000 + i);
        end
        wr(4'd9, 16'h1);
    endtask

    task automatic t_flush();
        int v;
        eng_push(16'h0101); eng_push(16'h0202);
        wr(4'd0, 16'h0303);
        @(negedge clk) enable = 1'b0;
        @(posedge clk); #1;
        rd(4'd1, v); chk("R9 tx flushed", v, 0);
        rd(4'd2, v); chk("R9 rx flushed", v, 0);
        wr(4'd0, 16'h0404);
        rd(4'd1, v); chk("R9 write ignored while disabled", v, 0);
        rd(4'd7, v); chk("R9 no overflow while disabled", (v >> 1) & 1, 0);
        @(negedge clk) enable = 1'b1;
        rd(4'd1, v); chk("R9 still empty after enable", v, 0);
    endtask

    task automatic t_status();
        int v;
        @(negedge clk); eng_busy = 1'b1; eng_tgt_busy = 1'b1;
        rd(4'd6, v); chk("R11 busy bits", v, 32'h2D);
        @(negedge clk); eng_busy = 1'b0;
        rd(4'd6, v); chk("R11 target busy only", v, 32'h2C);
        @(negedge clk); eng_tgt_busy = 1'b0;
        rd(4'd15, v); chk("R11 unmapped reads zero", v, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_thresholds();
        t_tx_path();
        t_rx_path();
        t_underflow();
        t_mask();
        t_tx_overflow();
        t_rx_overflow();
        t_flush();
        t_status();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule